// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Peripheral Hand-Over

This block controls one 8-pin I/O port. Each pin is either driven by software as a general-purpose I/O, or handed over to one of two on-chip peripheral sources. A software-owned pin takes its output value from the output-data register and its output enable from the direction register. A peripheral-owned pin takes both its value and its tri-state control from the source that its select bit picks.

Software reaches a small bank of byte-wide registers over a simple memory-mapped read/write bus. Reads are combinational and are decoded from the address alone. Writes take effect on the rising clock edge while select and write are both high. The pull-up and drive-strength enables go straight to the pad controls. The pad inputs pass through a two-flop synchronizer and can be read back as a read-only register in every pin mode.

Top module: `gpio_port_mux`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 except input-sample (offset 4h), and pad_oe, pad_out, pad_pu and pad_hd are all 0.
- R2: Each register can be written at its own offset and read back unchanged: ownership 0h, direction 2h, output-data 6h, pull-up 8h, drive-strength Ah, source-select Ch.
- R3: A write to the input-sample offset 4h changes nothing. A read of any odd offset, or of Eh or Fh, returns 0.
- R4: When ownership bit n is 0, pad_oe[n] equals direction bit n and pad_out[n] equals output-data bit n.
- R5: When ownership bit n is 1 and source-select bit n is 0, pad_out[n] and pad_oe[n] follow src0_out[n] and src0_oe[n].
- R6: When ownership bit n is 1 and source-select bit n is 1, pad_out[n] and pad_oe[n] follow src1_out[n] and src1_oe[n].
- R7: A read of offset 4h returns pad_in as it was sampled two rising edges earlier, in every pin mode.
- R8: pad_pu equals the pull-up register and pad_hd equals the drive-strength register, whatever the ownership bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Pad input buffer values, asynchronous |
| src0_out | input | 8 | Peripheral source 0 output values |
| src0_oe | input | 8 | Peripheral source 0 output enables |
| src1_out | input | 8 | Peripheral source 1 output values |
| src1_oe | input | 8 | Peripheral source 1 output enables |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables (1 = drive) |
| pad_pu | output | 8 | Weak pull-up enables |
| pad_hd | output | 8 | High drive-strength enables |

## Verification
The assertions take the bus inputs and the peripheral sources to be known and settled at each rising edge. They take pad_in to change at most once per cycle, so that the two-edge input-sample latency can be compared with a two-cycle history of the port. The stimulus changes every input only on the falling edge, and it keeps pad_in steady for at least two edges before it reads offset 4h. It also holds the bus idle whenever it checks pad outputs.

// File: rtl/gpio_port_pkg.sv
// Package: shared register offsets for the GPIO port.
// Assumes a 4-bit byte-offset bus in which only even offsets are mapped.
package gpio_port_pkg;
    typedef enum logic [3:0] {
        OFS_OWN  = 4'h0,
        OFS_DIR  = 4'h2,
        OFS_INS  = 4'h4,
        OFS_DAT  = 4'h6,
        OFS_PULL = 4'h8,
        OFS_DRV  = 4'hA,
        OFS_SRC  = 4'hC
    } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-bit two-flop synchronizer.
// Assumes each bit is independent; no coherence across bits is promised.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two capture stages, both cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;
endmodule

// File: rtl/gpio_regbank.sv
// Module: register bank of the port; writes on the clock edge, reads are combinational.
// Assumes ADDR_W is 4, matching the offsets in gpio_port_pkg.
module gpio_regbank
    import gpio_port_pkg::*;
#(
    parameter int W      = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      ins_val,
    output logic [W-1:0]      own_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      dat_q,
    output logic [W-1:0]      pull_q,
    output logic [W-1:0]      drv_q,
    output logic [W-1:0]      src_q
);
    localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_INS  = ADDR_W'(OFS_INS);
    localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(OFS_DAT);
    localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(OFS_PULL);
    localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(OFS_DRV);
    localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);

    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    // Register update: reset clears all, a write loads the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q  <= '0;
            dir_q  <= '0;
            dat_q  <= '0;
            pull_q <= '0;
            drv_q  <= '0;
            src_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_OWN:   own_q  <= bus_wdata;
                A_DIR:   dir_q  <= bus_wdata;
                A_DAT:   dat_q  <= bus_wdata;
                A_PULL:  pull_q <= bus_wdata;
                A_DRV:   drv_q  <= bus_wdata;
                A_SRC:   src_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Read decode: mapped offsets return their register, all others return zero.
    always_comb begin
        case (bus_addr)
            A_OWN:   bus_rdata = own_q;
            A_DIR:   bus_rdata = dir_q;
            A_INS:   bus_rdata = ins_val;
            A_DAT:   bus_rdata = dat_q;
            A_PULL:  bus_rdata = pull_q;
            A_DRV:   bus_rdata = drv_q;
            A_SRC:   bus_rdata = src_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Module: per-pin owner mux choosing software or one of two peripheral sources.
// Assumes the source select is consulted only while the pin is peripheral-owned.
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] src,
    input  logic [W-1:0] sw_dat,
    input  logic [W-1:0] sw_dir,
    input  logic [W-1:0] p0_out,
    input  logic [W-1:0] p0_oe,
    input  logic [W-1:0] p1_out,
    input  logic [W-1:0] p1_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        logic per_out;
        logic per_oe;
        // Pick the peripheral source, then the owner of this pin.
        always_comb begin
            per_out    = src[n] ? p1_out[n] : p0_out[n];
            per_oe     = src[n] ? p1_oe[n]  : p0_oe[n];
            pin_out[n] = own[n] ? per_out : sw_dat[n];
            pin_oe[n]  = own[n] ? per_oe  : sw_dir[n];
        end
    end
endmodule

// File: rtl/gpio_port_mux.sv
// Module: top of the byte-wide GPIO port with peripheral hand-over.
// Assumes pad_in is asynchronous and all other inputs are synchronous to clk.
module gpio_port_mux #(
    parameter int PIN_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    input  logic [PIN_W-1:0]  src0_out,
    input  logic [PIN_W-1:0]  src0_oe,
    input  logic [PIN_W-1:0]  src1_out,
    input  logic [PIN_W-1:0]  src1_oe,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_pu,
    output logic [PIN_W-1:0]  pad_hd
);
    logic [PIN_W-1:0] own_q, dir_q, dat_q, pull_q, drv_q, src_q, ins_q;

    gpio_sync #(.W(PIN_W)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (ins_q)
    );

    gpio_regbank #(.W(PIN_W), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ins_val   (ins_q),
        .own_q     (own_q),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .pull_q    (pull_q),
        .drv_q     (drv_q),
        .src_q     (src_q)
    );

    gpio_pin_mux #(.W(PIN_W)) i_mux (
        .own     (own_q),
        .src     (src_q),
        .sw_dat  (dat_q),
        .sw_dir  (dir_q),
        .p0_out  (src0_out),
        .p0_oe   (src0_oe),
        .p1_out  (src1_out),
        .p1_oe   (src1_oe),
        .pin_out (pad_out),
        .pin_oe  (pad_oe)
    );

    assign pad_pu = pull_q;
    assign pad_hd = drv_q;
endmodule

// File: rtl/gpio_port_chk.sv
// Module: assertion checker bound to gpio_port_mux.
// Assumes inputs change only away from the rising edge.
module gpio_port_chk #(
    parameter int PIN_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pad_in,
    input logic [PIN_W-1:0]  src0_out,
    input logic [PIN_W-1:0]  src0_oe,
    input logic [PIN_W-1:0]  src1_out,
    input logic [PIN_W-1:0]  src1_oe,
    input logic [PIN_W-1:0]  pad_out,
    input logic [PIN_W-1:0]  pad_oe,
    input logic [PIN_W-1:0]  pad_pu,
    input logic [PIN_W-1:0]  pad_hd,
    input logic [PIN_W-1:0]  own_q,
    input logic [PIN_W-1:0]  src_q,
    input logic [PIN_W-1:0]  dat_q,
    input logic [PIN_W-1:0]  ins_q
);
    logic [1:0] age_q;

    // Count edges since reset, saturating, so history checks start late enough.
    always_ff @(posedge clk) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (own_q == '0 && pad_oe == '0 && pad_pu == '0 && pad_hd == '0));

    // R2
    dat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(4'h6)) |=> dat_q == $past(bus_wdata));

    // R3
    odd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] |-> bus_rdata == '0);

    // R5
    src0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&own_q && src_q == '0) |-> (pad_out == src0_out && pad_oe == src0_oe));

    // R6
    src1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&own_q && &src_q) |-> (pad_out == src1_out && pad_oe == src1_oe));

    // R7
    ins_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> ins_q == $past(pad_in, 2));
endmodule

bind gpio_port_mux gpio_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .src0_out  (src0_out),
    .src0_oe   (src0_oe),
    .src1_out  (src1_out),
    .src1_oe   (src1_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_hd    (pad_hd),
    .own_q     (own_q),
    .src_q     (src_q),
    .dat_q     (dat_q),
    .ins_q     (ins_q)
);

// File: tb/test_gpio_port_mux.sv
module test_gpio_port_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pad_in = '0, src0_out = '0, src0_oe = '0, src1_out = '0, src1_oe = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_hd;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Bench model of the register bank
    logic [7:0] m_own = '0, m_dir = '0, m_dat = '0, m_pull = '0, m_drv = '0, m_src = '0, m_ins = '0;

    gpio_port_mux i_gpio_port_mux (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .src0_out(src0_out), .src0_oe(src0_oe),
        .src1_out(src1_out), .src1_oe(src1_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_hd(pad_hd)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_own;
            4'h2: return m_dir;
            4'h4: return m_ins;
            4'h6: return m_dat;
            4'h8: return m_pull;
            4'hA: return m_drv;
            4'hC: return m_src;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_out();
        return (m_own & ((m_src & src1_out) | (~m_src & src0_out))) | (~m_own & m_dat);
    endfunction

    function automatic logic [7:0] exp_oe();
        return (m_own & ((m_src & src1_oe) | (~m_src & src0_oe))) | (~m_own & m_dir);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (a)
            4'h0: m_own  = d;
            4'h2: m_dir  = d;
            4'h6: m_dat  = d;
            4'h8: m_pull = d;
            4'hA: m_drv  = d;
            4'hC: m_src  = d;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a);
        bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
        #1;
        chk(req, bus_rdata, exp_rd(a));
        bus_sel = 1'b0;
    endtask

    task automatic pads_chk(input string req);
        #1;
        chk({req, " pad_out"}, pad_out, exp_out());
        chk({req, " pad_oe"}, pad_oe, exp_oe());
        chk("R8 pad_pu", pad_pu, m_pull);
        chk("R8 pad_hd", pad_hd, m_drv);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        pads_chk("R1");
        for (int a = 0; a < 16; a++) rd_chk("R1", 4'(a));

        // R2: write and read back every writable register
        wr(4'h0, 8'h00); wr(4'h2, 8'h5A); wr(4'h6, 8'hC3);
        wr(4'h8, 8'h81); wr(4'hA, 8'h7E); wr(4'hC, 8'h99);
        rd_chk("R2", 4'h2); rd_chk("R2", 4'h6); rd_chk("R2", 4'h8);
        rd_chk("R2", 4'hA); rd_chk("R2", 4'hC); rd_chk("R2", 4'h0);

        // R3: input-sample write ignored, unmapped reads zero
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        m_ins = 8'h3C;
        wr(4'h4, 8'hFF);
        rd_chk("R3", 4'h4);
        for (int a = 1; a < 16; a += 2) rd_chk("R3", 4'(a));
        rd_chk("R3", 4'hE);

        // R4: all pins software-owned
        wr(4'h2, 8'hA5); wr(4'h6, 8'h0F);
        src0_out = 8'hFF; src0_oe = 8'hFF; src1_out = 8'hFF; src1_oe = 8'hFF;
        pads_chk("R4");

        // R5: all pins owned by source 0
        src0_out = 8'h6C; src0_oe = 8'h93; src1_out = 8'h11; src1_oe = 8'h22;
        wr(4'hC, 8'h00); wr(4'h0, 8'hFF);
        pads_chk("R5");

        // R6: all pins owned by source 1, pull/drive unchanged (R8)
        wr(4'hC, 8'hFF);
        pads_chk("R6");

        // Mixed ownership per pin
        wr(4'h0, 8'hF0); wr(4'hC, 8'h3C);
        pads_chk("R6 mixed");

        // R7: two-edge latency of the input sample, in peripheral mode
        @(negedge clk);
        pad_in = 8'hA7;
        @(negedge clk);
        rd_chk("R7 one edge", 4'h4);
        @(negedge clk);
        m_ins = 8'hA7;
        rd_chk("R7 two edges", 4'h4);

        // Random mix over all requirements
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            a = 4'($urandom_range(0, 15));
            @(negedge clk);
            pad_in   = 8'($urandom);
            src0_out = 8'($urandom); src0_oe = 8'($urandom);
            src1_out = 8'($urandom); src1_oe = 8'($urandom);
            wr(a, 8'($urandom));
            @(negedge clk);
            m_ins = pad_in;
            pads_chk("R4/R5/R6 random");
            rd_chk("R2/R3/R7 random", 4'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule